// File: doc/BRIEF.md
# Converter mode and calibration sequencer

This block is the register-side controller of a multichannel sigma-delta converter. A small register port (4-bit address, 8-bit data, write and read strobes) reaches four registers: status, mode, channel control and filter word. From these the block drives the converter reset pulse, the filter word the modulator actually uses, the positive and negative input multiplexer selects, and the index of the calibration register pair that belongs to the selected channel.

A write of a calibration mode starts a modelled calibration. A down-counter stands in for the modulator and sets the length of the calibration. When it expires, the block issues a one-cycle write of a fixed calibration result to the selected register pair, sets the ready and calibration-done flags, and returns the mode field to idle. While chopping is enabled, a calibration runs at the largest filter word, and the user's word comes back when the calibration ends. Any mode write restarts the converter. A mode write during a calibration aborts it.

Top module: `adc_cal_ctrl`

## Requirements
- R1: Register map, addressed by `reg_addr`. Address 0 is status (read only). Address 1 is mode: bits [2:0] mode field, bit 3 chop enable, bit 4 ten-input configuration, bits [7:5] read 0. Address 2 is channel control: bits [7:4] channel code, bit 3 unipolar, bits [2:0] range. Address 3 is the filter word. After reset, mode reads 0x01, control reads 0x07, the filter word reads 0x0F and status reads 0x00. Other addresses read 0.
- R2: Every write to address 1 raises `conv_reset` for the next cycle, even when the written value equals the held one. `conv_reset` is never high in the same cycle as `cal_wr`.
- R3: A mode write with bit 2 set is a calibration: bit 0 = 1 selects full scale and bit 0 = 0 selects zero scale. It clears the ready flag at the next edge. `cal_wr` rises exactly 4×(S+1) cycles after the write edge, where S is 0xFF if the written chop bit is 1 and the filter word otherwise.
- R4: On completion, `cal_wr` is high for one cycle. In that cycle `cal_wr_pair` holds the pair of the current channel code, `cal_wr_full` holds the calibration kind and `cal_wr_data` holds the fixed result. The ready and done flags are set, and the mode field reads 001.
- R5: With chop enabled, `eff_sf` is 0xFF for the whole calibration. It returns to the user's filter word once the calibration ends.
- R6: With chop disabled, or outside a calibration, `eff_sf` equals the filter word register.
- R7: Eight-input configuration (select codes: 0 common, 1–10 inputs 1–10, 11 reference+, 12 reference−, 15 open). Codes 0–7 select input c+1 against common, with pairs 1,2,3,4,1,2,3,4. Codes 8–11 select the differential pairs 1/2, 3/4, 5/6 and 7/8, with pairs 1–4. Code 12 selects 2/2, 13 common/common, 14 reference+/reference− and 15 open/open, all with pair 1.
- R8: Ten-input configuration. Codes 4, 5, 6 and 7 use pairs 5, 1, 2 and 3. Code 12 selects 9/10 with pair 5. Code 14 selects 9/common with pair 4. Code 15 selects 10/common with pair 5. All other codes match R7.
- R9: `zero_code` is 0x000000 when the unipolar bit is 1 and 0x800000 when it is 0.
- R10: A mode write during a calibration ends that calibration without any `cal_wr`. If the new value is itself a calibration, a fresh count starts.
- R11: Status reads back with ready in bit 7 and calibration done in bit 5. A read of address 0 with `reg_re` clears the done flag, unless a completion sets it at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (for clear-on-read) |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| conv_reset | output | 1 | Converter reset pulse |
| eff_sf | output | 8 | Filter word in use |
| pos_sel | output | 4 | Positive input select |
| neg_sel | output | 4 | Negative input select |
| cal_pair | output | 3 | Calibration pair of current channel |
| zero_code | output | 24 | Output code for zero input |
| cal_wr | output | 1 | Calibration register write pulse |
| cal_wr_pair | output | 3 | Pair written by `cal_wr` |
| cal_wr_full | output | 1 | 1 = full-scale result, 0 = zero-scale |
| cal_wr_data | output | 24 | Calibration result value |

## Verification
Register writes show on `conv_reset` and in the register reads one edge after the write, while the selects, `eff_sf` and `zero_code` follow the registers with no further delay. `cal_wr` and the ready flag arrive 4×(S+1) edges after the calibration write. The bench holds a behavioural model that it advances at every rising edge, and it compares every output 5 ns later, so each value is sampled only after its last register has settled. Dedicated counters also time each calibration from its write edge and count `cal_wr` pulses across an aborted run.

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl #(
  parameter logic [7:0]  SF_MAX     = 8'hFF,
  parameter logic [7:0]  SF_RST     = 8'h0F,
  parameter logic [23:0] CAL_RESULT = 24'h5AC331
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  input  logic        reg_re,
  output logic [7:0]  reg_rdata,
  output logic        conv_reset,
  output logic [7:0]  eff_sf,
  output logic [3:0]  pos_sel,
  output logic [3:0]  neg_sel,
  output logic [2:0]  cal_pair,
  output logic [23:0] zero_code,
  output logic        cal_wr,
  output logic [2:0]  cal_wr_pair,
  output logic        cal_wr_full,
  output logic [23:0] cal_wr_data
);
  localparam int          CNT_W  = 10;
  localparam logic [3:0]  A_STAT = 4'd0;
  localparam logic [3:0]  A_MODE = 4'd1;
  localparam logic [3:0]  A_CTRL = 4'd2;
  localparam logic [3:0]  A_FILT = 4'd3;
  localparam logic [2:0]  MD_IDLE = 3'b001;

  logic [2:0]       md;
  logic             chop, ten_in, busy, ready, cal_done, cal_full;
  logic [7:0]       ctrl, sf;
  logic [CNT_W-1:0] cnt;

  wire mode_wr = reg_we && (reg_addr == A_MODE);
  wire stat_rd = reg_re && (reg_addr == A_STAT);
  wire finish  = busy && (cnt == '0);
  wire [3:0] code = ctrl[7:4];

  assign eff_sf      = (busy && chop) ? SF_MAX : sf;
  assign zero_code   = ctrl[3] ? 24'h000000 : 24'h800000;
  assign cal_wr_data = CAL_RESULT;
  assign cal_wr_full = cal_full;

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {ready, 1'b0, cal_done, 5'b0};
      A_MODE:  reg_rdata = {3'b0, ten_in, chop, md};
      A_CTRL:  reg_rdata = ctrl;
      A_FILT:  reg_rdata = sf;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    pos_sel  = 4'd0;
    neg_sel  = 4'd0;
    cal_pair = 3'd1;
    if (!code[3]) begin
      pos_sel  = {1'b0, code[2:0]} + 4'd1;
      cal_pair = {1'b0, code[1:0]} + 3'd1;
      if (ten_in && code[2])
        cal_pair = (code[1:0] == 2'd0) ? 3'd5 : {1'b0, code[1:0]};
    end else if (!code[2]) begin
      pos_sel  = {1'b0, code[1:0], 1'b0} + 4'd1;
      neg_sel  = {1'b0, code[1:0], 1'b0} + 4'd2;
      cal_pair = {1'b0, code[1:0]} + 3'd1;
    end else begin
      case (code[1:0])
        2'd0: if (ten_in) begin pos_sel = 4'd9; neg_sel = 4'd10; cal_pair = 3'd5; end
              else begin pos_sel = 4'd2; neg_sel = 4'd2; end
        2'd1: ;
        2'd2: if (ten_in) begin pos_sel = 4'd9; cal_pair = 3'd4; end
              else begin pos_sel = 4'd11; neg_sel = 4'd12; end
        default: if (ten_in) begin pos_sel = 4'd10; cal_pair = 3'd5; end
                 else begin pos_sel = 4'd15; neg_sel = 4'd15; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md <= MD_IDLE; chop <= 1'b0; ten_in <= 1'b0;
      ctrl <= 8'h07; sf <= SF_RST;
      busy <= 1'b0; ready <= 1'b0; cal_done <= 1'b0; cal_full <= 1'b0;
      cnt <= '0; conv_reset <= 1'b0; cal_wr <= 1'b0; cal_wr_pair <= 3'd1;
    end else begin
      conv_reset <= mode_wr;
      cal_wr     <= 1'b0;
      if (reg_we && reg_addr == A_CTRL) ctrl <= reg_wdata;
      if (reg_we && reg_addr == A_FILT) sf   <= reg_wdata;
      if (stat_rd) cal_done <= 1'b0;
      if (mode_wr) begin
        md     <= reg_wdata[2:0];
        chop   <= reg_wdata[3];
        ten_in <= reg_wdata[4];
        busy   <= reg_wdata[2];
        if (reg_wdata[2]) begin
          ready    <= 1'b0;
          cal_full <= reg_wdata[0];
          cnt      <= {reg_wdata[3] ? SF_MAX : sf, 2'b11};
        end
      end else if (finish) begin
        busy        <= 1'b0;
        md          <= MD_IDLE;
        ready       <= 1'b1;
        cal_done    <= 1'b1;
        cal_wr      <= 1'b1;
        cal_wr_pair <= cal_pair;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R2
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_reset |-> !cal_wr);
  // R3
  cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && reg_wdata[2] |=> busy && !ready);
  // R4
  cal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> cal_wr && md == MD_IDLE && cal_done);
  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !cal_wr);
  // R5
  sf_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr |-> eff_sf == sf);
endmodule

// File: tb/adc_cal_ctrl_tb_top.sv
module adc_cal_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_rdata, eff_sf;
  logic conv_reset, cal_wr, cal_wr_full;
  logic [3:0] pos_sel, neg_sel;
  logic [2:0] cal_pair, cal_wr_pair;
  logic [23:0] zero_code, cal_wr_data;

  always #10 clk = ~clk;

  adc_cal_ctrl dut_i (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .conv_reset(conv_reset),
    .eff_sf(eff_sf), .pos_sel(pos_sel), .neg_sel(neg_sel), .cal_pair(cal_pair),
    .zero_code(zero_code), .cal_wr(cal_wr), .cal_wr_pair(cal_wr_pair),
    .cal_wr_full(cal_wr_full), .cal_wr_data(cal_wr_data));

  int checks = 0, errors = 0, n_calwr = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pos(int c, bit ten);
    if (c < 8) return c + 1;
    if (c < 12) return 2 * (c - 8) + 1;
    if (c == 12) return ten ? 9 : 2;
    if (c == 13) return 0;
    if (c == 14) return ten ? 9 : 11;
    return ten ? 10 : 15;
  endfunction
  function automatic int exp_neg(int c, bit ten);
    if (c < 8) return 0;
    if (c < 12) return 2 * (c - 8) + 2;
    if (c == 12) return ten ? 10 : 2;
    if (c == 13) return 0;
    if (c == 14) return ten ? 0 : 12;
    return ten ? 0 : 15;
  endfunction
  function automatic int exp_pair(int c, bit ten);
    if (c < 8) begin
      if (ten && c >= 4) return (c == 4) ? 5 : c - 4;
      return (c % 4) + 1;
    end
    if (c < 12) return c - 7;
    if (ten && (c == 12 || c == 15)) return 5;
    if (ten && c == 14) return 4;
    return 1;
  endfunction

  int m_md, m_ctrl, m_sf, m_left, m_wpair;
  bit m_chop, m_ten, m_busy, m_ready, m_done, m_full, m_wfull, m_creset, m_calwr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_md = 1; m_ctrl = 8'h07; m_sf = 8'h0F; m_left = 0; m_wpair = 1;
      m_chop = 0; m_ten = 0; m_busy = 0; m_ready = 0; m_done = 0;
      m_full = 0; m_wfull = 0; m_creset = 0; m_calwr = 0;
    end else begin
      m_creset = reg_we && reg_addr == 1;
      m_calwr = 0;
      if (reg_re && reg_addr == 0) m_done = 0;
      if (reg_we && reg_addr == 1) begin
        m_md = reg_wdata & 7; m_chop = reg_wdata[3]; m_ten = reg_wdata[4];
        m_busy = reg_wdata[2];
        if (reg_wdata[2]) begin
          m_ready = 0; m_full = reg_wdata[0];
          m_left = 4 * ((reg_wdata[3] ? 255 : m_sf) + 1);
        end
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_md = 1; m_ready = 1; m_done = 1; m_calwr = 1;
          m_wpair = exp_pair(m_ctrl / 16, m_ten); m_wfull = m_full;
        end
      end
      if (reg_we && reg_addr == 2) m_ctrl = reg_wdata;
      if (reg_we && reg_addr == 3) m_sf = reg_wdata;
    end
    #5;
    if (rst_n && !finished) begin
      int rd;
      case (reg_addr)
        0: rd = m_ready * 128 + m_done * 32;
        1: rd = m_ten * 16 + m_chop * 8 + m_md;
        2: rd = m_ctrl;
        3: rd = m_sf;
        default: rd = 0;
      endcase
      check((reg_addr == 0) ? "R11 status" : "R1 readback", reg_rdata, rd);
      check("R2 conv_reset", conv_reset, m_creset);
      check(m_chop ? "R5 eff_sf" : "R6 eff_sf", eff_sf, (m_busy && m_chop) ? 255 : m_sf);
      check(m_ten ? "R8 pos_sel" : "R7 pos_sel", pos_sel, exp_pos(m_ctrl / 16, m_ten));
      check(m_ten ? "R8 neg_sel" : "R7 neg_sel", neg_sel, exp_neg(m_ctrl / 16, m_ten));
      check(m_ten ? "R8 cal_pair" : "R7 cal_pair", cal_pair, exp_pair(m_ctrl / 16, m_ten));
      check("R9 zero_code", zero_code, m_ctrl[3] ? 0 : 32'h800000);
      check("R4 R10 cal_wr", cal_wr, m_calwr);
      if (cal_wr) begin
        n_calwr++;
        check("R4 cal_wr_pair", cal_wr_pair, m_wpair);
        check("R4 cal_wr_full", cal_wr_full, m_wfull);
        check("R4 cal_wr_data", cal_wr_data, 32'h5AC331);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    @(negedge clk); reg_re = 1'b0;
  endtask
  task automatic timed_cal(input logic [7:0] mode, input int expn);
    int k = 0;
    wr(4'd1, mode);
    while (k < 3000) begin
      @(posedge clk); #6; k++;
      if (cal_wr) break;
    end
    check("R3 calibration length", k, expn);
  endtask
  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset status", dut_i.reg_rdata, 8'h00);
    rd(4'd1); rd(4'd2); rd(4'd3); rd(4'd9);
    for (int ten = 0; ten < 2; ten++) begin
      wr(4'd1, 8'h01 | (ten << 4));
      for (int c = 0; c < 16; c++) wr(4'd2, (c << 4) | 7 | ((c & 1) << 3));
    end
    wr(4'd1, 8'h01);
    wr(4'd2, 8'h50);
    wr(4'd3, 8'h03);
    timed_cal(8'h04, 16);
    rd(4'd0); rd(4'd0); rd(4'd1);
    wr(4'd1, 8'h01); wr(4'd1, 8'h01);
    wr(4'd2, 8'h90);
    timed_cal(8'h0D, 1024);
    rd(4'd3); rd(4'd1);
    n_calwr = 0;
    wr(4'd1, 8'h04);
    repeat (5) @(negedge clk);
    wr(4'd1, 8'h01);
    repeat (40) @(negedge clk);
    check("R10 no write after abort", n_calwr, 0);
    wr(4'd1, 8'h04);
    repeat (3) @(negedge clk);
    timed_cal(8'h05, 16);
    wr(4'd2, 8'hC0);
    timed_cal(8'h14, 16);
    reg_addr = 4'd0; reg_re = 1'b1;
    @(negedge clk); reg_re = 1'b0;
    rd(4'd0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule